// File: doc/BRIEF.md
# Chip-select-gated two-byte UART transmitter

This block sends a 16-bit result word over one serial wire as two UART-format bytes. An external serial clock paces the link, with one bit per clock period, so that clock alone sets the baud rate. The block does not run a byte on its own. A byte starts only when the active-low chip select is found low at a falling serial-clock edge while the line is idle. The upper half of the word goes first. The lower half goes out on the next chip-select request. Between frames the serial output is released, and the enable output shows when the pin is driven.

On the converter side, a one-cycle strobe loads a new word into an output register and raises a data-ready flag. The register is locked while a byte is in flight, and a strobe that arrives then is lost. Between the two bytes the register can be overwritten. In that case the byte pointer returns to the upper half, so the receiver gets the start of the new word. All logic runs on the falling edge of the serial clock and uses a synchronous reset.

Top module: `cs_uart_pair_tx`

## Requirements
- R1: A synchronous reset releases the serial output (enable low), clears data-ready and sets the byte pointer to the upper byte. The held word is kept, so the next byte sent after reset is the upper byte of the last loaded word.
- R2: When the line is idle and armed, and chip select is low at a falling edge, a frame starts at that edge. Its first bit time drives logic 0 with the enable high.
- R3: The eight data bits follow the start bit, one per serial-clock period, least significant bit first.
- R4: Two stop bits at logic 1 follow the data bits. At the next falling edge the enable drops, so a frame spans exactly 11 bit times.
- R5: The first byte of a word carries bits 15..8. The following byte carries bits 7..0.
- R6: A new frame needs chip select to have been seen high since the last frame started. If chip select is held low after a frame, the line stays released.
- R7: A word strobe taken at the edge where a frame starts, or at any edge while a frame is in flight (including the edge that ends it), is discarded. The held word and the byte pointer are unchanged.
- R8: A word strobe taken while the line is idle loads the word and returns the pointer to the upper byte, even when only the upper byte of the previous word has been sent.
- R9: Data-ready goes high one edge after an accepted strobe. It stays high after the upper byte and clears at the edge that ends the lower byte's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | External serial clock. All state changes on its falling edge. |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select that requests one byte |
| word_vld_i | input | 1 | One-cycle strobe: a new word is present on word_i |
| word_i | input | 16 | New result word |
| sdata_o | output | 1 | Serial data, meaningful only while sdata_oe_o is high |
| sdata_oe_o | output | 1 | High while a frame is driven. Low means high impedance. |
| drdy_o | output | 1 | High while a loaded word has not been fully sent |

## Verification
Two things can collide: a word strobe and a frame boundary at the same falling edge. The bench raises the strobe at the very edge where chip select starts a frame, in the middle of a frame, and at the edge that ends a frame. In each case it checks that the bytes sent afterwards still come from the old word. It also loads a new word in the idle gap between the upper and lower bytes and checks that the next byte is the new upper byte. Both outcomes are judged purely from the bit stream on the serial pin and the data-ready flag.

// File: rtl/csu_pkg.sv
package csu_pkg;
  function automatic int unsigned frame_bits(int unsigned byte_w, int unsigned stop_bits);
    return 1 + byte_w + stop_bits;
  endfunction
endpackage

// File: rtl/csu_start_gate.sv
module csu_start_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cs_n_i,
  input  logic busy_i,
  output logic start_o
);
  logic armed_q;

  assign start_o = !busy_i && !cs_n_i && armed_q;

  // armed again only once chip select is seen high
  always_ff @(negedge clk_i) begin
    if (rst_i)        armed_q <= 1'b1;
    else if (start_o) armed_q <= 1'b0;
    else if (cs_n_i)  armed_q <= 1'b1;
  end
endmodule

// File: rtl/csu_word_hold.sv
module csu_word_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  load_i,
  input  logic [2*BYTE_W-1:0]   word_i,
  input  logic                  lock_i,
  input  logic                  done_i,
  output logic [BYTE_W-1:0]     byte_o,
  output logic [2*BYTE_W-1:0]   word_o,
  output logic                  upper_o,
  output logic                  rdy_o
);
  localparam int unsigned WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] word_q;
  logic              accept;

  assign accept = load_i && !lock_i;
  assign word_o = word_q;
  assign byte_o = upper_o ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];

  // data register carries no reset
  always_ff @(negedge clk_i) begin
    if (accept) word_q <= word_i;
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      upper_o <= 1'b1;
      rdy_o   <= 1'b0;
    end else if (accept) begin
      upper_o <= 1'b1;
      rdy_o   <= 1'b1;
    end else if (done_i) begin
      if (!upper_o) rdy_o <= 1'b0;
      upper_o <= !upper_o;
    end
  end
endmodule

// File: rtl/csu_frame_tx.sv
module csu_frame_tx #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              sd_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned LAST  = csu_pkg::frame_bits(BYTE_W, STOP_BITS) - 1;
  localparam int unsigned CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] DATA_C = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  // cnt_q is the index of the bit now on the line: 0 start, 1..BYTE_W data, then stops
  assign done_o = busy_o && (cnt_q == LAST_C);

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      busy_o <= 1'b0;
      oe_o   <= 1'b0;
      sd_o   <= 1'b1;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      oe_o   <= 1'b1;
      sd_o   <= 1'b0;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_o <= 1'b0;
      oe_o   <= 1'b0;
      sd_o   <= 1'b1;
    end else if (busy_o) begin
      cnt_q <= cnt_q + 1'b1;
      sd_o  <= (cnt_q < DATA_C) ? sh_q[0] : 1'b1;
    end
  end

  always_ff @(negedge clk_i) begin
    if (start_i)                      sh_q <= byte_i;
    else if (busy_o && cnt_q < DATA_C) sh_q <= {1'b0, sh_q[BYTE_W-1:1]};
  end
endmodule

// File: rtl/cs_uart_pair_tx.sv
module cs_uart_pair_tx #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic                  sclk_i,
  input  logic                  rst_i,
  input  logic                  cs_n_i,
  input  logic                  word_vld_i,
  input  logic [2*BYTE_W-1:0]   word_i,
  output logic                  sdata_o,
  output logic                  sdata_oe_o,
  output logic                  drdy_o
);
  logic                start_w;
  logic                busy_w;
  logic                done_w;
  logic                upper_w;
  logic [BYTE_W-1:0]   byte_w;
  logic [2*BYTE_W-1:0] word_w;

  csu_start_gate u_gate (
    .clk_i   (sclk_i),
    .rst_i   (rst_i),
    .cs_n_i  (cs_n_i),
    .busy_i  (busy_w),
    .start_o (start_w)
  );

  csu_word_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk_i   (sclk_i),
    .rst_i   (rst_i),
    .load_i  (word_vld_i),
    .word_i  (word_i),
    .lock_i  (busy_w || start_w),
    .done_i  (done_w),
    .byte_o  (byte_w),
    .word_o  (word_w),
    .upper_o (upper_w),
    .rdy_o   (drdy_o)
  );

  csu_frame_tx #(.BYTE_W(BYTE_W), .STOP_BITS(STOP_BITS)) u_frame (
    .clk_i   (sclk_i),
    .rst_i   (rst_i),
    .start_i (start_w),
    .byte_i  (byte_w),
    .sd_o    (sdata_o),
    .oe_o    (sdata_oe_o),
    .busy_o  (busy_w),
    .done_o  (done_w)
  );
endmodule

// File: rtl/cs_uart_pair_tx_chk.sv
module cs_uart_pair_tx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              word_vld_i,
  input logic              sd_i,
  input logic              oe_i,
  input logic              drdy_i,
  input logic              busy_i,
  input logic              start_i,
  input logic [WORD_W-1:0] word_q_i
);
  p_reset_idle_r1: assert property (@(negedge clk_i)
    rst_i |=> (!oe_i && !drdy_i));

  p_start_low_r2: assert property (@(negedge clk_i) disable iff (rst_i)
    $rose(oe_i) |-> !sd_i);

  p_rise_needs_start_r2: assert property (@(negedge clk_i) disable iff (rst_i)
    $rose(oe_i) |-> $past(start_i));

  p_stop_before_idle_r4: assert property (@(negedge clk_i) disable iff (rst_i)
    $fell(oe_i) |-> $past(sd_i));

  p_locked_r7: assert property (@(negedge clk_i) disable iff (rst_i)
    ((busy_i || start_i) && word_vld_i) |=> $stable(word_q_i));

  p_rdy_on_load_r9: assert property (@(negedge clk_i) disable iff (rst_i)
    (word_vld_i && !busy_i && !start_i) |=> drdy_i);
endmodule

bind cs_uart_pair_tx cs_uart_pair_tx_chk #(.WORD_W(2*BYTE_W)) u_chk (
  .clk_i      (sclk_i),
  .rst_i      (rst_i),
  .word_vld_i (word_vld_i),
  .sd_i       (sdata_o),
  .oe_i       (sdata_oe_o),
  .drdy_i     (drdy_o),
  .busy_i     (busy_w),
  .start_i    (start_w),
  .word_q_i   (word_w)
);

// File: tb/test_cs_uart_pair_tx.sv
module test_cs_uart_pair_tx;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        vld = 1'b0;
  logic [15:0] word = '0;
  logic        sd, oe, rdy;
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  cs_uart_pair_tx i_cs_uart_pair_tx (
    .sclk_i     (clk),
    .rst_i      (rst),
    .cs_n_i     (cs_n),
    .word_vld_i (vld),
    .word_i     (word),
    .sdata_o    (sd),
    .sdata_oe_o (oe),
    .drdy_o     (rdy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // strobe captured at the falling edge between the two rising edges
  task automatic load_word(input logic [15:0] w);
    @(posedge clk); vld = 1'b1; word = w;
    @(posedge clk); vld = 1'b0;
    chk("R9 ready after load", 16'(rdy), 16'd1);
  endtask

  // strobe_j: -1 none, 0 with cs low, j>0 at the j-th following rising edge
  task automatic send_byte(input logic [7:0] exp_b, input string req, input int strobe_j,
                           input logic [15:0] sw, input bit hold_low, input logic exp_rdy);
    @(posedge clk);
    cs_n = 1'b0;
    if (strobe_j == 0) begin vld = 1'b1; word = sw; end
    for (int k = 0; k <= 10; k++) begin
      logic eb;
      @(posedge clk);
      eb = (k == 0) ? 1'b0 : (k <= 8) ? exp_b[k-1] : 1'b1;
      chk("R2 enable in frame", 16'(oe), 16'd1);
      if (k == 0)      chk("R2 start bit", 16'(sd), 16'(eb));
      else if (k <= 8) chk({"R3 data bit ", req}, 16'(sd), 16'(eb));
      else             chk("R4 stop bit", 16'(sd), 16'(eb));
      if (vld) vld = 1'b0;
      if (strobe_j == k + 1) begin vld = 1'b1; word = sw; end
      if (k == 0 && !hold_low) cs_n = 1'b1;
    end
    @(posedge clk);
    vld = 1'b0;
    chk("R4 released after frame", 16'(oe), 16'd0);
    chk("R9 ready after frame", 16'(rdy), 16'(exp_rdy));
    if (hold_low) begin
      for (int i = 0; i < 5; i++) begin
        @(posedge clk);
        chk("R6 no restart while held low", 16'(oe), 16'd0);
      end
      cs_n = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(posedge clk);
    chk("R1 reset enable", 16'(oe), 16'd0);
    chk("R1 reset ready", 16'(rdy), 16'd0);

    // sweep of words, both bytes each (R5)
    for (int k = 0; k < 26; k++) begin
      logic [15:0] w;
      w = (k == 25) ? 16'hFFFF : 16'((k * 40503) ^ (k << 5));
      load_word(w);
      send_byte(w[15:8], "R5 upper", -1, '0, 1'b0, 1'b1);
      send_byte(w[7:0],  "R5 lower", -1, '0, 1'b0, 1'b0);
    end

    // R7: strobes at frame start, mid frame and at the ending edge are lost
    load_word(16'hA55A);
    send_byte(8'hA5, "R7 start collision", 0, 16'h1234, 1'b0, 1'b1);
    send_byte(8'h5A, "R7 mid frame", 5, 16'h4321, 1'b0, 1'b0);
    load_word(16'h3CC3);
    send_byte(8'h3C, "R7 end edge", 11, 16'h7777, 1'b0, 1'b1);
    send_byte(8'hC3, "R7 lower kept", -1, '0, 1'b0, 1'b0);

    // R8: overwrite between bytes
    load_word(16'h0F81);
    send_byte(8'h0F, "R8 old upper", -1, '0, 1'b0, 1'b1);
    load_word(16'hE46B);
    send_byte(8'hE4, "R8 new upper", -1, '0, 1'b0, 1'b1);
    send_byte(8'h6B, "R8 new lower", -1, '0, 1'b0, 1'b0);

    // R6: chip select held low after a frame
    load_word(16'h9266);
    send_byte(8'h92, "R6 upper", -1, '0, 1'b1, 1'b1);
    send_byte(8'h66, "R6 lower", -1, '0, 1'b0, 1'b0);

    // R1: reset between bytes returns pointer to upper, word kept
    load_word(16'hB7D4);
    send_byte(8'hB7, "R1 before reset", -1, '0, 1'b0, 1'b1);
    @(posedge clk); rst = 1'b1;
    @(posedge clk); rst = 1'b0;
    @(posedge clk);
    chk("R1 ready cleared", 16'(rdy), 16'd0);
    chk("R1 enable low", 16'(oe), 16'd0);
    send_byte(8'hB7, "R1 upper after reset", -1, '0, 1'b0, 1'b0);
    send_byte(8'hD4, "R1 lower after reset", -1, '0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule